// File: doc/BRIEF.md
# Settling-Detect Measurement Sequencer

This block runs one terminal measurement on an external test front end. On a start request it captures a code byte and an address byte, then writes them over a single shared byte bus into two external latches. Each latch has its own active-low strobe, and a common active-low write enable is asserted while either strobe is active. It then waits for the front end's acquisition-done interrupt and reads a result through a fixed read-select handshake.

After each read the sequencer waits out a long programmable settling delay and pulses a conversion-enable line to start a new acquisition. It reads again and compares the new value with the previous one. The loop ends when two consecutive results differ by no more than a tolerance. It then reports the later result, the number of disagreeing comparisons, and the number of clock cycles the transient took to die out. If an interrupt does not arrive within a timeout window, the measurement ends with an error flag and an all-ones result.

All durations are clock-cycle counts set by parameters. The defaults suit a 125 MHz clock: about 12 µs strobes and read samples, an 80 ms settling wait and a 0.1 s interrupt timeout.

Top module: `meas_seq`

## Requirements
- R1: While idle and after reset, `ctrl_o` is 4'b1011 (no strobe, no write enable, no read select), `cv_en_o`, `busy_o`, `done_o` and `error_o` are 0, and `data_o` is 0.
- R2: An accepted start first drives the captured code on `data_o` with the code strobe asserted for exactly STB_CYC cycles. It then drives the captured address with the address strobe asserted for exactly STB_CYC cycles. The two strobes are never active together, and `data_o` is 0 outside them.
- R3: `ctrl_o` is a logical control word XORed with 4'b1011. Bit 0 is the code strobe (low = active), bit 1 the address strobe (low = active), bit 2 the read select (high = active) and bit 3 the write enable (low = active). The write enable is active whenever either strobe is.
- R4: The read select rises only in the cycle after `irq_i` was sampled high while waiting. It stays high for exactly SAMPLE_CYC cycles, and `res_i` is captured in its last cycle.
- R5: After a read that does not end the measurement, the sequencer stays quiet for SETTLE_CYC cycles, then pulses `cv_en_o` for one cycle, then waits for the next interrupt.
- R6: The measurement settles at the first read whose value differs from the previous read by at most TOL (absolute difference). `result_o` is that later read.
- R7: `retries_o` equals the number of consecutive-read comparisons that exceeded TOL before settling (or before a timeout).
- R8: If `irq_i` is not seen within TIMEOUT_CYC cycles of any wait, the measurement ends with `error_o`=1, `result_o` all ones and `trans_len_o`=0.
- R9: `trans_len_o` equals the number of clock cycles from the end of the first read to the end of the settling read.
- R10: `done_o` is a one-cycle pulse in the cycle after the measurement ends. `busy_o` is already low in that cycle, and `result_o`, `error_o`, `retries_o` and `trans_len_o` change only together with `done_o`.
- R11: `code_i` and `addr_i` are captured only when a start is accepted. `start_i` is ignored while `busy_o` is high and does not queue a further measurement.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| code_i | input | DATA_W | Current code to latch |
| addr_i | input | DATA_W | Pin address to latch |
| irq_i | input | 1 | Acquisition-done interrupt from the front end |
| res_i | input | RES_W | Result bus from the front end |
| data_o | output | DATA_W | Shared latch data bus |
| ctrl_o | output | 4 | Control port word, XOR-masked with 4'b1011 |
| cv_en_o | output | 1 | One-cycle conversion-enable pulse |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Interrupt timeout occurred |
| result_o | output | RES_W | Settled result, all ones on error |
| retries_o | output | RETRY_W | Disagreeing comparisons, saturating |
| trans_len_o | output | LEN_W | Transient length in cycles, saturating |

## Verification
On every cycle, the assertions check the port-level rules: strobe exclusion and its coupling to the write enable, the quiet idle port, the interrupt preceding each read-select rise, the one-cycle conversion and done pulses, and that outputs move only with `done_o`. Only the bench scenarios can show the outcomes that depend on sequences of readings. These are which read settles for a given difference pattern, the retry count, the arithmetic transient length under varying interrupt latency, exact strobe and sample durations, and both timeout paths. The bench also shows that a start during a run is dropped.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COD,
    ST_ADR,
    ST_WAIT,
    ST_READ,
    ST_SETTLE,
    ST_CV
  } seq_state_e;

  // port polarity: bits 0,1,3 active low, bit 2 active high
  localparam logic [3:0] CTRL_MASK = 4'b1011;
  localparam int CB_COD = 0;
  localparam int CB_ADR = 1;
  localparam int CB_RD  = 2;
  localparam int CB_WE  = 3;

endpackage

// File: rtl/meas_timer.sv
module meas_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/meas_tol_cmp.sv
module meas_tol_cmp #(
  parameter int W   = 10,
  parameter int TOL = 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         near_o
);
  logic [W-1:0] diff;

  always_comb begin
    diff   = (a_i > b_i) ? (a_i - b_i) : (b_i - a_i);
    near_o = (diff <= W'(TOL));
  end
endmodule

// File: rtl/meas_ctrl_enc.sv
module meas_ctrl_enc
  import meas_seq_pkg::*;
(
  input  logic       cod_i,
  input  logic       adr_i,
  input  logic       rd_i,
  output logic [3:0] ctrl_o
);
  logic [3:0] word;

  always_comb begin
    word         = '0;
    word[CB_COD] = cod_i;
    word[CB_ADR] = adr_i;
    word[CB_RD]  = rd_i;
    word[CB_WE]  = cod_i | adr_i;
    ctrl_o       = word ^ CTRL_MASK;
  end
endmodule

// File: rtl/meas_seq.sv
module meas_seq
  import meas_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RES_W       = 10,
  parameter int STB_CYC     = 1500,
  parameter int SAMPLE_CYC  = 1500,
  parameter int SETTLE_CYC  = 10_000_000,
  parameter int TIMEOUT_CYC = 12_500_000,
  parameter int TOL         = 2,
  parameter int RETRY_W     = 8,
  parameter int LEN_W       = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DATA_W-1:0]  code_i,
  input  logic [DATA_W-1:0]  addr_i,
  input  logic               irq_i,
  input  logic [RES_W-1:0]   res_i,
  output logic [DATA_W-1:0]  data_o,
  output logic [3:0]         ctrl_o,
  output logic               cv_en_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               error_o,
  output logic [RES_W-1:0]   result_o,
  output logic [RETRY_W-1:0] retries_o,
  output logic [LEN_W-1:0]   trans_len_o
);
  localparam int MAX_AB  = (STB_CYC > SAMPLE_CYC) ? STB_CYC : SAMPLE_CYC;
  localparam int MAX_CD  = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] LD_STB    = CNT_W'(STB_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SAMPLE = CNT_W'(SAMPLE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TO     = CNT_W'(TIMEOUT_CYC - 1);

  seq_state_e state_q, state_d;

  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             near;

  logic              accept, cap_first, cap_retry, fin_ok, fin_err;
  logic [DATA_W-1:0] code_q, addr_q;
  logic [RES_W-1:0]  prev_q;
  logic              first_q, meas_q;
  logic [RETRY_W-1:0] retry_q;
  logic [LEN_W-1:0]  len_q;

  logic               done_q, error_q;
  logic [RES_W-1:0]   result_q;
  logic [RETRY_W-1:0] retries_q;
  logic [LEN_W-1:0]   tlen_q;

  meas_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  meas_tol_cmp #(.W(RES_W), .TOL(TOL)) u_cmp (
    .a_i    (prev_q),
    .b_i    (res_i),
    .near_o (near)
  );

  meas_ctrl_enc u_enc (
    .cod_i  (state_q == ST_COD),
    .adr_i  (state_q == ST_ADR),
    .rd_i   (state_q == ST_READ),
    .ctrl_o (ctrl_o)
  );

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    accept    = 1'b0;
    cap_first = 1'b0;
    cap_retry = 1'b0;
    fin_ok    = 1'b0;
    fin_err   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_COD; tmr_load = 1'b1; tmr_val = LD_STB; accept = 1'b1;
      end
      ST_COD: if (tmr_zero) begin
        state_d = ST_ADR; tmr_load = 1'b1; tmr_val = LD_STB;
      end
      ST_ADR: if (tmr_zero) begin
        state_d = ST_WAIT; tmr_load = 1'b1; tmr_val = LD_TO;
      end
      ST_WAIT: begin
        if (irq_i) begin
          state_d = ST_READ; tmr_load = 1'b1; tmr_val = LD_SAMPLE;
        end else if (tmr_zero) begin
          state_d = ST_IDLE; fin_err = 1'b1;
        end
      end
      ST_READ: if (tmr_zero) begin
        if (first_q) begin
          cap_first = 1'b1;
          state_d = ST_SETTLE; tmr_load = 1'b1; tmr_val = LD_SETTLE;
        end else if (near) begin
          fin_ok  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cap_retry = 1'b1;
          state_d = ST_SETTLE; tmr_load = 1'b1; tmr_val = LD_SETTLE;
        end
      end
      ST_SETTLE: if (tmr_zero) state_d = ST_CV;
      ST_CV: begin
        state_d = ST_WAIT; tmr_load = 1'b1; tmr_val = LD_TO;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      code_q    <= '0;
      addr_q    <= '0;
      prev_q    <= '0;
      first_q   <= 1'b0;
      meas_q    <= 1'b0;
      retry_q   <= '0;
      len_q     <= '0;
      done_q    <= 1'b0;
      error_q   <= 1'b0;
      result_q  <= '0;
      retries_q <= '0;
      tlen_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_ok | fin_err;

      if (meas_q && len_q != '1) len_q <= len_q + 1'b1;

      if (accept) begin
        code_q  <= code_i;
        addr_q  <= addr_i;
        first_q <= 1'b1;
        meas_q  <= 1'b0;
        retry_q <= '0;
        len_q   <= '0;
      end
      if (cap_first) begin
        prev_q  <= res_i;
        first_q <= 1'b0;
        meas_q  <= 1'b1;
        len_q   <= '0;
      end
      if (cap_retry) begin
        prev_q <= res_i;
        if (retry_q != '1) retry_q <= retry_q + 1'b1;
      end
      if (fin_ok) begin
        meas_q    <= 1'b0;
        error_q   <= 1'b0;
        result_q  <= res_i;
        retries_q <= retry_q;
        tlen_q    <= (len_q == '1) ? len_q : len_q + 1'b1;
      end
      if (fin_err) begin
        meas_q    <= 1'b0;
        error_q   <= 1'b1;
        result_q  <= '1;
        retries_q <= retry_q;
        tlen_q    <= '0;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_COD:  data_o = code_q;
      ST_ADR:  data_o = addr_q;
      default: data_o = '0;
    endcase
  end

  assign cv_en_o     = (state_q == ST_CV);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign error_o     = error_q;
  assign result_o    = result_q;
  assign retries_o   = retries_q;
  assign trans_len_o = tlen_q;

endmodule

// File: rtl/meas_seq_chk.sv
module meas_seq_chk #(
  parameter int RES_W   = 10,
  parameter int RETRY_W = 8,
  parameter int LEN_W   = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_i,
  input logic [3:0]         ctrl_o,
  input logic               cv_en_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               error_o,
  input logic [RES_W-1:0]   result_o,
  input logic [RETRY_W-1:0] retries_o,
  input logic [LEN_W-1:0]   trans_len_o
);
  p_strobe_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ctrl_o[0] && !ctrl_o[1]));

  p_we_with_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[0] || !ctrl_o[1]) |-> !ctrl_o[3]);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ctrl_o == 4'b1011 && !cv_en_o));

  p_read_after_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[2]) |-> $past(irq_i));

  p_cv_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cv_en_o |=> (!cv_en_o && !ctrl_o[2]));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(result_o) && $stable(error_o) && $stable(retries_o) && $stable(trans_len_o))
      |-> done_o);

  p_err_result_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && error_o) |-> (result_o == '1 && trans_len_o == '0));
endmodule

bind meas_seq meas_seq_chk #(
  .RES_W(RES_W), .RETRY_W(RETRY_W), .LEN_W(LEN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_i),
  .ctrl_o      (ctrl_o),
  .cv_en_o     (cv_en_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .error_o     (error_o),
  .result_o    (result_o),
  .retries_o   (retries_o),
  .trans_len_o (trans_len_o)
);

// File: tb/tb_meas_seq.sv
module tb_meas_seq;
  localparam int DW = 8, RW = 10, STB = 3, SAMPLE = 2, SETTLE = 5, TIMEOUT = 40;
  localparam int TOL = 2, RTW = 4, LW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start_i = 1'b0, irq_i = 1'b0;
  logic [DW-1:0] code_i = '0, addr_i = '0;
  logic [RW-1:0] res_i = '0;
  logic [DW-1:0] data_o;
  logic [3:0] ctrl_o;
  logic cv_en_o, busy_o, done_o, error_o;
  logic [RW-1:0] result_o;
  logic [RTW-1:0] retries_o;
  logic [LW-1:0] trans_len_o;

  meas_seq #(.DATA_W(DW), .RES_W(RW), .STB_CYC(STB), .SAMPLE_CYC(SAMPLE),
    .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TIMEOUT), .TOL(TOL), .RETRY_W(RTW),
    .LEN_W(LW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .code_i(code_i),
    .addr_i(addr_i), .irq_i(irq_i), .res_i(res_i), .data_o(data_o),
    .ctrl_o(ctrl_o), .cv_en_o(cv_en_o), .busy_o(busy_o), .done_o(done_o),
    .error_o(error_o), .result_o(result_o), .retries_o(retries_o),
    .trans_len_o(trans_len_o));

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // front-end model and port monitor
  logic [RW-1:0] seq_r [0:7];
  int seq_idx = 0, irq_lat = 0, irq_budget = 0, fe_cnt = 0;
  bit fe_pend = 1'b0;
  logic [3:0] ctrl_prev = 4'b1011;
  logic [DW-1:0] exp_code, exp_addr;
  int n_cod, n_adr, n_reads, rd_bad, n_cv, n_quiet, data_bad, order_bad, run;
  bit seen_adr;

  task automatic clr_mon();
    n_cod = 0; n_adr = 0; n_reads = 0; rd_bad = 0; n_cv = 0; n_quiet = 0;
    data_bad = 0; order_bad = 0; run = 0; seen_adr = 1'b0;
    seq_idx = 0; fe_pend = 1'b0;
  endtask

  always @(negedge clk) begin
    irq_i = 1'b0;
    if (fe_pend) begin
      if (fe_cnt == 0) begin
        irq_i = 1'b1;
        res_i = seq_r[seq_idx];
        if (seq_idx < 7) seq_idx++;
        fe_pend = 1'b0;
      end else fe_cnt--;
    end
    if (irq_budget > 0 && ((!ctrl_prev[1] && ctrl_o[1]) || cv_en_o)) begin
      fe_pend = 1'b1; fe_cnt = irq_lat; irq_budget--;
    end
    ctrl_prev = ctrl_o;
    if (!ctrl_o[0]) begin
      n_cod++;
      if (data_o != exp_code) data_bad++;
      if (seen_adr) order_bad++;
    end
    if (!ctrl_o[1]) begin
      n_adr++; seen_adr = 1'b1;
      if (data_o != exp_addr) data_bad++;
    end
    if ((!ctrl_o[0] || !ctrl_o[1]) && ctrl_o[3]) data_bad++;
    if (ctrl_o[0] && ctrl_o[1] && data_o != '0) data_bad++;
    if (ctrl_o[2]) run++;
    else if (run != 0) begin
      if (run != SAMPLE) rd_bad++;
      n_reads++; run = 0;
    end
    if (cv_en_o) n_cv++;
    if (busy_o && ctrl_o == 4'b1011 && !cv_en_o) n_quiet++;
  end

  logic [RW-1:0]  got_res;
  logic [RTW-1:0] got_rt;
  logic [LW-1:0]  got_len;
  logic           got_err;

  task automatic run_meas(input logic [DW-1:0] c, input logic [DW-1:0] a,
                          input int lat, input int budget);
    @(negedge clk);
    clr_mon();
    exp_code = c; exp_addr = a; irq_lat = lat; irq_budget = budget;
    start_i = 1'b1; code_i = c; addr_i = a;
    @(negedge clk);
    start_i = 1'b0; code_i = ~c; addr_i = ~a;
    while (!done_o) @(negedge clk);
    got_res = result_o; got_rt = retries_o; got_len = trans_len_o; got_err = error_o;
    chk(!busy_o, "R10", "busy at done", busy_o, 0);
    @(negedge clk);
    chk(!done_o, "R10", "done width", done_o, 0);
    repeat (3) @(negedge clk);
    chk(result_o == got_res && retries_o == got_rt, "R10", "hold result",
        result_o, got_res);
  endtask

  function automatic int settle_k();
    for (int k = 1; k < 4; k++) begin
      int df = int'(seq_r[k]) - int'(seq_r[k-1]);
      if (df <= TOL && df >= -TOL) return k;
    end
    return 3;
  endfunction

  task automatic common_prog(input string tag);
    chk(n_cod == STB, "R2", {tag, " code strobe cycles"}, n_cod, STB);
    chk(n_adr == STB, "R2", {tag, " addr strobe cycles"}, n_adr, STB);
    chk(order_bad == 0, "R2", {tag, " strobe order"}, order_bad, 0);
    chk(data_bad == 0, "R3", {tag, " bus data/write enable"}, data_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clr_mon();
    exp_code = '0; exp_addr = '0;
    for (int i = 0; i < 8; i++) seq_r[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctrl_o == 4'b1011, "R1", "ctrl idle", ctrl_o, 11);
    chk(!cv_en_o && !busy_o && !done_o && !error_o, "R1", "flags idle",
        {cv_en_o, busy_o, done_o, error_o}, 0);
    chk(data_o == '0 && result_o == '0, "R1", "bus/result idle", data_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ctrl_o == 4'b1011 && !busy_o, "R1", "idle after reset", ctrl_o, 11);

    // R6 R7 R9 sweep of reading differences and latencies
    foreach (seq_r[i]) seq_r[i] = '0;
    for (int b = 0; b < 2; b++) begin
      for (int d1 = -4; d1 <= 4; d1++) begin
        for (int d2 = -4; d2 <= 4; d2++) begin
          int base = (b == 0) ? 5 : 1018;
          int lat = (d1 + d2 + 8) % 3;
          int k, exp_len;
          seq_r[0] = RW'(base);
          seq_r[1] = RW'(base + d1);
          seq_r[2] = RW'(base + d1 + d2);
          seq_r[3] = seq_r[2];
          k = settle_k();
          exp_len = k * (SETTLE + SAMPLE + lat + 2);
          run_meas(DW'(d1 * 16 + d2 + 64 + b), DW'(d2 * 8 - d1 + 128 + b), lat, 8);
          chk(!got_err, "R6", "no error", got_err, 0);
          chk(got_res == seq_r[k], "R6", "settled value", got_res, seq_r[k]);
          chk(got_rt == RTW'(k - 1), "R7", "retries", got_rt, k - 1);
          chk(n_cv == k, "R5", "conversion pulses", n_cv, k);
          chk(n_reads == k + 1 && rd_bad == 0, "R4", "read handshakes", n_reads, k + 1);
          chk(got_len == LW'(exp_len), "R9", "transient length", got_len, exp_len);
          common_prog("sweep");
        end
      end
    end

    // R8 timeout on the first interrupt
    run_meas(8'hA5, 8'h3C, 0, 0);
    chk(got_err, "R8", "error flag", got_err, 1);
    chk(got_res == '1, "R8", "error code", got_res, 1023);
    chk(got_len == '0 && got_rt == '0, "R8", "len/retries", got_len, 0);
    chk(n_quiet == TIMEOUT, "R8", "timeout window", n_quiet, TIMEOUT);
    chk(n_reads == 0, "R4", "no read without irq", n_reads, 0);
    common_prog("timeout");

    // R8 R7 timeout after one disagreement
    seq_r[0] = 10'd100; seq_r[1] = 10'd110; seq_r[2] = 10'd120;
    run_meas(8'h11, 8'h22, 1, 2);
    chk(got_err, "R8", "mid error flag", got_err, 1);
    chk(got_res == '1, "R8", "mid error code", got_res, 1023);
    chk(got_rt == 4'd1, "R7", "mid retries", got_rt, 1);
    chk(n_reads == 2 && n_cv == 2, "R5", "mid reads/pulses", n_reads, 2);

    // R11 start while busy is dropped, inputs captured at accept
    seq_r[0] = 10'd300; seq_r[1] = 10'd308; seq_r[2] = 10'd309;
    fork
      run_meas(8'h5A, 8'hC3, 2, 8);
      begin
        repeat (4) @(negedge clk);
        start_i = 1'b1; code_i = 8'hFF; addr_i = 8'h00;
        repeat (10) @(negedge clk);
        start_i = 1'b0;
      end
    join
    chk(got_res == 10'd309 && got_rt == 4'd1, "R11", "result unaffected", got_res, 309);
    chk(n_cod == STB && data_bad == 0, "R11", "single programming", n_cod, STB);
    repeat (6) @(negedge clk);
    chk(!busy_o && n_cod == STB, "R11", "no queued run", busy_o, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule